// File: doc/BRIEF.md
# Masked serial pin writer

This block owns the output shadow of an 8-bit general-purpose port and uses two groups of its pins as a software-free serial link: one group acts as a clock, the other carries data. Each byte handed to it is shifted out one bit at a time. For every bit it drives the clock pins low, then puts the data value on the data pins, then drives the clock pins high. A typical use is streaming a configuration image into a programmable logic device. The data pins are settled a full phase before the clock rises, which meets setup times of a few nanoseconds.

A configuration word picks the clock pins, the data pins and the bit order. It is only accepted when both pin groups touch at least one writable pin and at least one pin configured as an output. Otherwise both masks are cleared and the writer is disarmed. Every update is a read-modify-write of the shadow, so pins outside the two masks keep whatever value the host last wrote.

Bytes enter on a valid/ready stream. `s_ready` is high only while the writer is idle. A byte is taken on a clock edge where `s_valid` and `s_ready` are both high. The source must hold `s_valid` and `s_data` until that edge. No byte is taken while a byte is shifting, and that back-pressure lasts 24 × (prescale + 1) cycles per byte.

Top module: `pin_shift_writer`

## Requirements
- R1: On `cfg_load` while idle, the writer captures `cfg_word[7:0]` as the clock mask, `cfg_word[15:8]` as the data mask and `cfg_word[16]` as MSB-first. A `cfg_load` while a byte is shifting is ignored.
- R2: A loaded configuration is kept only if the clock mask and the data mask each overlap `wr_mask` and each overlap `dir_out`. Otherwise both masks become zero. `cfg_armed` is high exactly when both stored masks are nonzero.
- R3: A byte accepted while disarmed is discarded. In the cycle after acceptance `perm_err` is high for one cycle and `port_q` is unchanged.
- R4: Each bit takes three phases in order: clock pins cleared, data pins set to the bit value, clock pins set. Each phase lasts prescale+1 cycles. The first update lands on the accepting edge, and each later update lands prescale+1 edges after the one before it.
- R5: With MSB-first set, bits leave in order 7 down to 0. Otherwise they leave in order 0 up to 7.
- R6: While shifting, port bits outside the clock and data masks never change.
- R7: `s_ready` is low from the accepting edge until 24×(prescale+1) edges later. At that edge `done` rises for exactly one cycle, and `s_ready` is high again.
- R8: `port_wr` while idle loads `port_wdata` into `port_q` on the next edge. `port_wr` while shifting is ignored.
- R9: After reset `port_q` is 0, both masks are zero, `cfg_armed`, `done` and `perm_err` are low and `s_ready` is high.
- R10: The prescale value is sampled when a byte is accepted. Changes to `presc` during the byte have no effect on that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load configuration word |
| cfg_word | input | 17 | Clock mask [7:0], data mask [15:8], MSB-first [16] |
| wr_mask | input | 8 | Pins the writer may modify |
| dir_out | input | 8 | Pins currently configured as outputs |
| cfg_armed | output | 1 | Both masks valid |
| presc | input | 4 | Phase length minus one, in cycles |
| s_valid | input | 1 | Byte available |
| s_data | input | 8 | Byte to shift |
| s_ready | output | 1 | Writer idle, byte can be taken |
| port_wr | input | 1 | Host write to the shadow (idle only) |
| port_wdata | input | 8 | Host shadow value |
| port_q | output | 8 | Port shadow register |
| done | output | 1 | One-cycle pulse after a byte's last bit |
| perm_err | output | 1 | One-cycle pulse for a byte refused while disarmed |

## Verification
The bound checker watches several rules on every cycle:
- pins outside the masks stay fixed while shifting;
- the masks stay frozen during a byte;
- the shadow is quiet when idle unless a host write occurs;
- a byte taken while disarmed raises `perm_err` and leaves the shadow alone;
- `done` is a lone pulse coinciding with readiness.

The exact phase sequence, the bit order, the phase length, the field positions and the acceptance rule for configurations are value-dependent. Only the bench's scenarios show these, by comparing the port cycle by cycle against a model.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  typedef enum logic [1:0] {
    PH_CLK_LO = 2'd0,
    PH_DATA   = 2'd1,
    PH_CLK_HI = 2'd2
  } phase_t;
endpackage

// File: rtl/pbw_cfg_gate.sv
module pbw_cfg_gate #(
  parameter int PORT_W = 8,
  localparam int CFG_W = 2 * PORT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CFG_W-1:0]  word,
  input  logic [PORT_W-1:0] wr_mask,
  input  logic [PORT_W-1:0] dir_out,
  output logic [PORT_W-1:0] clk_m,
  output logic [PORT_W-1:0] dat_m,
  output logic              msb_first,
  output logic              armed
);
  logic [PORT_W-1:0] c_req, d_req;
  logic              legal;

  assign c_req = word[PORT_W-1:0];
  assign d_req = word[2*PORT_W-1:PORT_W];
  assign legal = (|(c_req & wr_mask)) && (|(d_req & wr_mask)) &&
                 (|(c_req & dir_out)) && (|(d_req & dir_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_m     <= '0;
      dat_m     <= '0;
      msb_first <= 1'b0;
    end else if (load) begin
      clk_m     <= legal ? c_req : '0;
      dat_m     <= legal ? d_req : '0;
      msb_first <= word[CFG_W-1];
    end
  end

  assign armed = (|clk_m) && (|dat_m);
endmodule

// File: rtl/pbw_sequencer.sv
module pbw_sequencer
  import pbw_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 4,
  localparam int IDX_W  = $clog2(BYTE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic [PRESC_W-1:0] presc_in,
  input  logic               msb_in,
  output logic               busy,
  output logic               upd,
  output phase_t             upd_ph,
  output logic               upd_bit,
  output logic               done
);
  phase_t             ph;
  logic [PRESC_W-1:0] tmr, presc_q;
  logic [IDX_W-1:0]   idx, idx_eff;
  logic [BYTE_W-1:0]  byte_q;
  logic               msb_q;
  logic               expire, last;

  assign expire = busy && (tmr == '0);
  assign last   = (ph == PH_CLK_HI) && (idx == IDX_W'(BYTE_W - 1));
  assign upd    = start || (expire && !last);

  always_comb begin
    if (start) begin
      upd_ph = PH_CLK_LO;
    end else begin
      case (ph)
        PH_CLK_LO: upd_ph = PH_DATA;
        PH_DATA:   upd_ph = PH_CLK_HI;
        default:   upd_ph = PH_CLK_LO;
      endcase
    end
  end

  assign idx_eff = msb_q ? (IDX_W'(BYTE_W - 1) - idx) : idx;
  assign upd_bit = byte_q[idx_eff];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ph      <= PH_CLK_LO;
      tmr     <= '0;
      presc_q <= '0;
      idx     <= '0;
      byte_q  <= '0;
      msb_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        ph      <= PH_CLK_LO;
        tmr     <= presc_in;
        presc_q <= presc_in;
        idx     <= '0;
        byte_q  <= byte_in;
        msb_q   <= msb_in;
      end else if (busy) begin
        if (tmr != '0) begin
          tmr <= tmr - 1'b1;
        end else if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          tmr <= presc_q;
          ph  <= upd_ph;
          if (ph == PH_CLK_HI) idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pbw_pin_shadow.sv
module pbw_pin_shadow
  import pbw_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [PORT_W-1:0] host_data,
  input  logic              upd,
  input  phase_t            upd_ph,
  input  logic              upd_bit,
  input  logic [PORT_W-1:0] clk_m,
  input  logic [PORT_W-1:0] dat_m,
  output logic [PORT_W-1:0] port_q
);
  logic [PORT_W-1:0] base, nxt;
  logic              do_lo, do_dat, do_hi;

  assign base   = host_wr ? host_data : port_q;
  assign do_lo  = upd && (upd_ph == PH_CLK_LO);
  assign do_dat = upd && (upd_ph == PH_DATA);
  assign do_hi  = upd && (upd_ph == PH_CLK_HI);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    assign nxt[i] = (do_lo  && clk_m[i]) ? 1'b0    :
                    (do_hi  && clk_m[i]) ? 1'b1    :
                    (do_dat && dat_m[i]) ? upd_bit :
                    base[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= RST_VAL;
    else        port_q <= nxt;
  end
endmodule

// File: rtl/pin_shift_writer.sv
module pin_shift_writer
  import pbw_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 4,
  localparam int CFG_W  = 2 * PORT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic [PORT_W-1:0]  wr_mask,
  input  logic [PORT_W-1:0]  dir_out,
  output logic               cfg_armed,
  input  logic [PRESC_W-1:0] presc,
  input  logic               s_valid,
  input  logic [BYTE_W-1:0]  s_data,
  output logic               s_ready,
  input  logic               port_wr,
  input  logic [PORT_W-1:0]  port_wdata,
  output logic [PORT_W-1:0]  port_q,
  output logic               done,
  output logic               perm_err
);
  logic [PORT_W-1:0] clk_m, dat_m;
  logic              msb_first, busy, accept, start;
  logic              upd, upd_bit;
  phase_t            upd_ph;

  assign s_ready = !busy;
  assign accept  = s_valid && s_ready;
  assign start   = accept && cfg_armed;

  pbw_cfg_gate #(.PORT_W(PORT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load && !busy), .word(cfg_word),
    .wr_mask(wr_mask), .dir_out(dir_out), .clk_m(clk_m), .dat_m(dat_m),
    .msb_first(msb_first), .armed(cfg_armed)
  );

  pbw_sequencer #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_in(s_data),
    .presc_in(presc), .msb_in(msb_first), .busy(busy), .upd(upd),
    .upd_ph(upd_ph), .upd_bit(upd_bit), .done(done)
  );

  pbw_pin_shadow #(.PORT_W(PORT_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .host_wr(port_wr && !busy),
    .host_data(port_wdata), .upd(upd), .upd_ph(upd_ph), .upd_bit(upd_bit),
    .clk_m(clk_m), .dat_m(dat_m), .port_q(port_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perm_err <= 1'b0;
    else        perm_err <= accept && !cfg_armed;
  end
endmodule

// File: rtl/pin_shift_writer_chk.sv
module pin_shift_writer_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              armed,
  input logic              perm_err,
  input logic              done,
  input logic              port_wr,
  input logic [PORT_W-1:0] port_q,
  input logic [PORT_W-1:0] clk_m,
  input logic [PORT_W-1:0] dat_m
);
  assert_drop_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !armed && !port_wr |=> perm_err && $stable(port_q));

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && armed |=> !s_ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> s_ready);

  assert_outside_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready && $past(!s_ready) |->
      ((port_q ^ $past(port_q)) & ~(clk_m | dat_m)) == '0);

  assert_masks_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready && $past(!s_ready) |-> $stable(clk_m) && $stable(dat_m));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready && $past(s_ready) && !$past(port_wr) |-> $stable(port_q));
endmodule

bind pin_shift_writer pin_shift_writer_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .armed(cfg_armed), .perm_err(perm_err), .done(done), .port_wr(port_wr),
  .port_q(port_q), .clk_m(clk_m), .dat_m(dat_m)
);

// File: tb/pin_shift_writer_test.sv
module pin_shift_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [16:0] cfg_word = '0;
  logic [7:0]  wr_mask = '0, dir_out = '0;
  logic        cfg_armed;
  logic [3:0]  presc = '0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        port_wr = 1'b0;
  logic [7:0]  port_wdata = '0;
  logic [7:0]  port_q;
  logic        done, perm_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] e_port = '0, e_clk = '0, e_dat = '0;
  logic       e_msb = 1'b0;
  int unsigned seed_val;

  always #4 clk = ~clk;

  pin_shift_writer uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .wr_mask(wr_mask), .dir_out(dir_out), .cfg_armed(cfg_armed),
    .presc(presc), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_q(port_q),
    .done(done), .perm_err(perm_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit cfg_legal(input logic [7:0] c, d, w, dr);
    return (|(c & w)) && (|(d & w)) && (|(c & dr)) && (|(d & dr));
  endfunction

  function automatic logic [7:0] apply_phase(input logic [7:0] p, input int ph,
                                             input logic b);
    logic [7:0] r = p;
    if (ph == 0) r = r & ~e_clk;
    else if (ph == 1) r = b ? (r | e_dat) : (r & ~e_dat);
    else r = r | e_clk;
    return r;
  endfunction

  task automatic load_cfg(input logic [7:0] c, d, input logic m,
                          input logic [7:0] w, dr);
    bit ok;
    cfg_word = {m, d, c}; wr_mask = w; dir_out = dr; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    ok = cfg_legal(c, d, w, dr);
    e_clk = ok ? c : 8'h00;
    e_dat = ok ? d : 8'h00;
    e_msb = m;
    chk(cfg_armed == ok, "R2 armed after load", 32'(cfg_armed), 32'(ok));
  endtask

  task automatic host_write(input logic [7:0] v);
    port_wr = 1'b1; port_wdata = v;
    @(negedge clk);
    port_wr = 1'b0;
    e_port = v;
    chk(port_q == v, "R8 idle host write", 32'(port_q), 32'(v));
  endtask

  task automatic send_unarmed(input logic [7:0] b);
    s_valid = 1'b1; s_data = b;
    chk(s_ready == 1'b1, "R3 ready while disarmed", 32'(s_ready), 1);
    @(negedge clk);
    s_valid = 1'b0;
    chk(perm_err == 1'b1, "R3 perm_err pulse", 32'(perm_err), 1);
    chk(port_q == e_port, "R3 port untouched", 32'(port_q), 32'(e_port));
    @(negedge clk);
    chk(perm_err == 1'b0, "R3 perm_err one cycle", 32'(perm_err), 0);
  endtask

  task automatic put_byte(input logic [7:0] b, input int pr, input bit disturb);
    int P = pr + 1;
    s_valid = 1'b1; s_data = b; presc = 4'(pr);
    chk(s_ready == 1'b1, "R7 ready before byte", 32'(s_ready), 1);
    @(negedge clk);
    s_valid = 1'b0;
    presc = 4'(pr + 5);
    for (int k = 0; k < 24; k++) begin
      int bi = k / 3;
      logic bv = e_msb ? b[7 - bi] : b[bi];
      e_port = apply_phase(e_port, k % 3, bv);
      chk(port_q == e_port, "R4 R5 phase value", 32'(port_q), 32'(e_port));
      chk(s_ready == 1'b0, "R7 ready low while shifting", 32'(s_ready), 0);
      if (disturb && k == 4) begin
        port_wr = 1'b1; port_wdata = ~e_port;
        cfg_word = {1'b1, 8'h0F, 8'hF0}; wr_mask = 8'hFF; dir_out = 8'hFF;
        cfg_load = 1'b1;
      end
      for (int c = 0; c < P; c++) begin
        @(negedge clk);
        port_wr = 1'b0; cfg_load = 1'b0;
        if (c < P - 1)
          chk(port_q == e_port, "R10 phase held prescale+1 cycles",
              32'(port_q), 32'(e_port));
      end
    end
    chk(done == 1'b1, "R7 done at end", 32'(done), 1);
    chk(s_ready == 1'b1, "R7 ready at end", 32'(s_ready), 1);
    chk(port_q == e_port, "R6 final port", 32'(port_q), 32'(e_port));
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    seed_val = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    chk(port_q == 8'h00, "R9 reset port", 32'(port_q), 0);
    chk(s_ready == 1'b1, "R9 reset ready", 32'(s_ready), 1);
    chk(cfg_armed == 1'b0, "R9 reset disarmed", 32'(cfg_armed), 0);
    chk(done == 1'b0 && perm_err == 1'b0, "R9 reset pulses low",
        32'({done, perm_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send_unarmed(8'h5A);
    host_write(8'hA5);
    load_cfg(8'h01, 8'h02, 1'b1, 8'hFF, 8'h01);
    send_unarmed(8'h11);
    load_cfg(8'h01, 8'h02, 1'b1, 8'hFD, 8'hFF);
    load_cfg(8'h01, 8'h02, 1'b1, 8'hFF, 8'hFF);
    put_byte(8'hB4, 0, 1'b0);
    load_cfg(8'h10, 8'h40, 1'b0, 8'hF0, 8'hF0);
    host_write(8'h2B);
    put_byte(8'h3C, 2, 1'b1);
    chk(cfg_armed == 1'b1, "R1 load during byte ignored", 32'(cfg_armed), 1);
    put_byte(8'h81, 1, 1'b0);

    for (int it = 0; it < 14; it++) begin
      logic [7:0] c = 8'(1 << ($urandom % 8));
      logic [7:0] d = 8'($urandom) & ~c;
      logic [7:0] w = 8'($urandom) | (it[0] ? 8'h00 : (c | d));
      logic [7:0] dr = 8'($urandom) | (it[1] ? 8'h00 : (c | d));
      load_cfg(c, d, 1'($urandom), w, dr);
      host_write(8'($urandom));
      if (cfg_armed) put_byte(8'($urandom), int'($urandom % 4), 1'($urandom));
      else send_unarmed(8'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule